// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File with Bank Window Decode

This block is the software-visible register set of an SDRAM controller. Software reaches it through two register ports. One port holds an internal offset. The other port reads or writes the register that this stored offset selects. The set holds:

- two error-status words and an error-address word;
- a global configuration word and a read-only status word;
- refresh, power-management and timing words;
- ECC configuration and ECC status words;
- four bank-configuration words.

Each register applies its own write mask. The power-management word also has fixed bits that are always set.

The block also decodes an incoming physical address against the four bank windows and returns a one-hot hit. A window is active only when its bank is marked valid, its size code is usable, and the controller is globally enabled. The block drives an ECC interrupt whenever the stored ECC status is nonzero. Command sequencing and the data path are outside this block.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: After reset the data port reads these values:
  - power-management (offset 0x34) = 0x07C00000
  - refresh (0x30) = 0x05F00000
  - timing (0x80) = 0x00854009
  - config (0x20) = 0x00800000
  - every other defined register = 0
  - bank_hit = 0 and ecc_irq = 0.
- R2: The ports are selected by the port index, and each has its own behaviour:
  - a write to index 0x10 stores an offset, and a read there returns that offset;
  - an access at index 0x11 reads or writes the register the stored offset selects;
  - any other index reads 0.
- R3: A data-port read at an offset that names no register returns 0xFFFFFFFF.
- R4: The two error-status words (offsets 0x00 and 0x08) clear the bits written as one. They therefore read 0 after any write from reset. The error-address word (0x10) stores all 32 bits written.
- R5: A config write (0x20) keeps only bits 31:21. Bit 31 is the global enable, and its changes act on status (offset 0x24) and on the windows:
  - a change of bit 31 from 0 to 1 clears status bit 31 and activates the bank windows;
  - a change from 1 to 0 sets status bit 31 and deactivates all windows.
- R6: Status bit 30 takes the new value of config bit 30 whenever that config bit changes. Writes to status (0x24) have no effect.
- R7: Writes keep these bits:
  - refresh (0x30): mask 0x3FF80000;
  - timing (0x80): mask 0x018FC01F;
  - ECC config (0x94): mask 0x00F00000;
  - power-management (0x34): keeps bits 31:27 and always reads with 0x07C00000 set.
- R8: Bank words live at offsets 0x40, 0x44, 0x48 and 0x4C for banks 0 to 3. A write keeps the bits under mask 0xFFDEE001. In a bank word, bits 31:23 are the base, bits 19:17 are the size code, and bit 0 is valid.
- R9: A bank hits when four conditions all hold:
  - the bank is valid;
  - the controller is enabled;
  - the size code is not 7;
  - the address bits at and above position 22+code equal the same bits of the base (bits below 23 of the base read as 0).

  The bank window size is 4 MB shifted left by the code. bank_hit bit i stands for bank i and follows the stored state combinationally.
- R10: bank_hit is one-hot or zero. When windows overlap, the lowest-numbered matching bank wins.
- R11: An ECC status write (0x98) keeps mask 0xFFF0F000. ecc_irq is 1 exactly while the stored ECC status is nonzero. It rises after a nonzero store and falls after a zero store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register port access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 10 | Register port index (0x10 offset port, 0x11 data port) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the port selected by acc_sel (combinational) |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | 4 | One-hot bank window hit |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
A data-port write to a bank word can land in the same cycle as an address decode that depends on that bank. The bench holds a physical address steady and then issues a bank write that opens a window over it. It samples bank_hit just before the capturing edge, expecting the old result of no hit. It samples again after that edge, expecting the new bank's bit. The same pairing is judged for global enable and disable writes against a standing hit.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
    localparam int NBANK  = 4;
    localparam int DW     = 32;
    localparam int IDX_W  = 10;

    localparam logic [IDX_W-1:0] PORT_OFS  = 10'h010;
    localparam logic [IDX_W-1:0] PORT_DATA = 10'h011;

    localparam logic [DW-1:0] OFS_ERR0  = 32'h00;
    localparam logic [DW-1:0] OFS_ERR1  = 32'h08;
    localparam logic [DW-1:0] OFS_EADR  = 32'h10;
    localparam logic [DW-1:0] OFS_CFG   = 32'h20;
    localparam logic [DW-1:0] OFS_STAT  = 32'h24;
    localparam logic [DW-1:0] OFS_RFSH  = 32'h30;
    localparam logic [DW-1:0] OFS_PWR   = 32'h34;
    localparam logic [DW-1:0] OFS_BANK  = 32'h40;
    localparam logic [DW-1:0] OFS_TIME  = 32'h80;
    localparam logic [DW-1:0] OFS_ECFG  = 32'h94;
    localparam logic [DW-1:0] OFS_ESTS  = 32'h98;

    localparam logic [DW-1:0] MSK_CFG   = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_RFSH  = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_PWR   = 32'hF800_0000;
    localparam logic [DW-1:0] FIX_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_TIME  = 32'h018F_C01F;
    localparam logic [DW-1:0] MSK_ECFG  = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_ESTS  = 32'hFFF0_F000;
    localparam logic [DW-1:0] MSK_BANK  = 32'hFFDE_E001;
    localparam logic [DW-1:0] MSK_BASE  = 32'hFF80_0000;

    localparam logic [DW-1:0] RST_CFG   = 32'h0080_0000;
    localparam logic [DW-1:0] RST_RFSH  = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] RST_TIME  = 32'h0085_4009;

    localparam int EN_BIT   = 31;
    localparam int SR_BIT   = 30;
    localparam int MIN_LOG2 = 22;

    typedef struct packed {
        logic [DW-1:0]            ofs;
        logic [DW-1:0]            err0;
        logic [DW-1:0]            err1;
        logic [DW-1:0]            eadr;
        logic [DW-1:0]            cfg;
        logic [DW-1:0]            stat;
        logic [DW-1:0]            rfsh;
        logic [DW-1:0]            pwr;
        logic [DW-1:0]            tim;
        logic [DW-1:0]            ecfg;
        logic [DW-1:0]            ests;
        logic [NBANK-1:0][DW-1:0] bank;
    } cfg_state_t;

    function automatic logic [DW-1:0] bank_ofs(input int i);
        return OFS_BANK + DW'(4 * i);
    endfunction
endpackage

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ofs,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    output cfg_state_t    st_q
);
    cfg_state_t st_d;
    logic [DW-1:0] cfg_new;

    always_comb begin
        st_d    = st_q;
        cfg_new = wdata & MSK_CFG;
        if (wr_ofs) begin
            st_d.ofs = wdata;
        end else if (wr_data) begin
            case (st_q.ofs)
                OFS_ERR0: st_d.err0 = st_q.err0 & ~wdata;
                OFS_ERR1: st_d.err1 = st_q.err1 & ~wdata;
                OFS_EADR: st_d.eadr = wdata;
                OFS_CFG: begin
                    if (!st_q.cfg[EN_BIT] && cfg_new[EN_BIT])
                        st_d.stat[EN_BIT] = 1'b0;
                    else if (st_q.cfg[EN_BIT] && !cfg_new[EN_BIT])
                        st_d.stat[EN_BIT] = 1'b1;
                    if (st_q.cfg[SR_BIT] != cfg_new[SR_BIT])
                        st_d.stat[SR_BIT] = cfg_new[SR_BIT];
                    st_d.cfg = cfg_new;
                end
                OFS_RFSH: st_d.rfsh = wdata & MSK_RFSH;
                OFS_PWR:  st_d.pwr  = (wdata & MSK_PWR) | FIX_PWR;
                OFS_TIME: st_d.tim  = wdata & MSK_TIME;
                OFS_ECFG: st_d.ecfg = wdata & MSK_ECFG;
                OFS_ESTS: st_d.ests = wdata & MSK_ESTS;
                default: begin
                    for (int i = 0; i < NBANK; i++)
                        if (st_q.ofs == bank_ofs(i))
                            st_d.bank[i] = wdata & MSK_BANK;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg  <= RST_CFG;
            st_q.rfsh <= RST_RFSH;
            st_q.pwr  <= RST_PWR;
            st_q.tim  <= RST_TIME;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    stat_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !wr_ofs && st_q.ofs == OFS_STAT) |=> $stable(st_q.stat));

    // R5
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cfg[EN_BIT]) |-> !st_q.stat[EN_BIT]);

    // R5
    enable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cfg[EN_BIT]) |-> st_q.stat[EN_BIT]);

    // R7
    pwr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pwr & FIX_PWR) == FIX_PWR);

    // R4
    err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !wr_ofs && st_q.ofs == OFS_ERR0) |=> ((st_q.err0 & $past(wdata)) == '0));
endmodule

// File: rtl/sdram_cfg_rdmux.sv
module sdram_cfg_rdmux
    import sdram_cfg_pkg::*;
(
    input  logic [IDX_W-1:0] sel,
    input  cfg_state_t       st,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] data_word;

    always_comb begin
        case (st.ofs)
            OFS_ERR0: data_word = st.err0;
            OFS_ERR1: data_word = st.err1;
            OFS_EADR: data_word = st.eadr;
            OFS_CFG:  data_word = st.cfg;
            OFS_STAT: data_word = st.stat;
            OFS_RFSH: data_word = st.rfsh;
            OFS_PWR:  data_word = st.pwr;
            OFS_TIME: data_word = st.tim;
            OFS_ECFG: data_word = st.ecfg;
            OFS_ESTS: data_word = st.ests;
            default: begin
                data_word = '1;
                for (int i = 0; i < NBANK; i++)
                    if (st.ofs == bank_ofs(i))
                        data_word = st.bank[i];
            end
        endcase
    end

    always_comb begin
        if (sel == PORT_OFS)
            rdata = st.ofs;
        else if (sel == PORT_DATA)
            rdata = data_word;
        else
            rdata = '0;
    end
endmodule

// File: rtl/sdram_bank_decode.sv
module sdram_bank_decode
    import sdram_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [NBANK-1:0][DW-1:0] bank,
    input  logic [DW-1:0]            addr,
    output logic [NBANK-1:0]         hit
);
    logic [NBANK-1:0] match;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [2:0]    code;
        logic [DW-1:0] span;
        logic [DW-1:0] keep;
        assign code  = bank[g][19:17];
        assign span  = DW'(1) << (MIN_LOG2 + 32'(code));
        assign keep  = ~(span - DW'(1));
        assign match[g] = enable && bank[g][0] && (code != 3'd7) &&
                          ((addr & keep) == (bank[g] & MSK_BASE & keep));
    end

    always_comb begin
        hit = '0;
        for (int i = NBANK - 1; i >= 0; i--)
            if (match[i]) hit = NBANK'(1) << i;
    end

    // R10
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R9
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> enable);
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [IDX_W-1:0]    acc_sel,
    input  logic [DW-1:0]       acc_wdata,
    output logic [DW-1:0]       acc_rdata,
    input  logic [DW-1:0]       phys_addr,
    output logic [NBANK-1:0]    bank_hit,
    output logic                ecc_irq
);
    cfg_state_t st_q;
    logic wr_ofs, wr_data;

    assign wr_ofs  = acc_en && acc_wr && (acc_sel == PORT_OFS);
    assign wr_data = acc_en && acc_wr && (acc_sel == PORT_DATA);

    sdram_cfg_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ofs  (wr_ofs),
        .wr_data (wr_data),
        .wdata   (acc_wdata),
        .st_q    (st_q)
    );

    sdram_cfg_rdmux i_rdmux (
        .sel   (acc_sel),
        .st    (st_q),
        .rdata (acc_rdata)
    );

    sdram_bank_decode i_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (st_q.cfg[EN_BIT]),
        .bank   (st_q.bank),
        .addr   (phys_addr),
        .hit    (bank_hit)
    );

    assign ecc_irq = |st_q.ests;

    // R11
    ecc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && st_q.ofs == OFS_ESTS && ((acc_wdata & MSK_ESTS) != '0)) |=> ecc_irq);

    // R11
    ecc_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && st_q.ofs == OFS_ESTS && ((acc_wdata & MSK_ESTS) == '0)) |=> !ecc_irq);
endmodule

// File: tb/test_sdram_cfg_regfile.sv
`timescale 1ns/1ps
module test_sdram_cfg_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [9:0]  acc_sel = '0;
    logic [31:0] acc_wdata = '0, acc_rdata, phys_addr = '0;
    logic [3:0]  bank_hit;
    logic        ecc_irq;
    int checks = 0, fails = 0;
    bit done = 0;

    localparam logic [9:0] P_OFS = 10'h010, P_DAT = 10'h011;

    always #4 clk = ~clk;

    sdram_cfg_regfile i_sdram_cfg_regfile (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .phys_addr(phys_addr), .bank_hit(bank_hit), .ecc_irq(ecc_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic port_wr(input logic [9:0] idx, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_sel = idx; acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic port_rd(input logic [9:0] idx, output logic [31:0] v);
        acc_sel = idx;
        #1 v = acc_rdata;
    endtask

    task automatic reg_wr(input logic [31:0] ofs, input logic [31:0] d);
        port_wr(P_OFS, ofs);
        port_wr(P_DAT, d);
    endtask

    task automatic reg_chk(input string req, input logic [31:0] ofs, input logic [31:0] exp);
        logic [31:0] v;
        port_wr(P_OFS, ofs);
        port_rd(P_DAT, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        reg_chk("R1 err0", 32'h00, 32'h0);
        reg_chk("R1 err1", 32'h08, 32'h0);
        reg_chk("R1 eadr", 32'h10, 32'h0);
        reg_chk("R1 cfg", 32'h20, 32'h0080_0000);
        reg_chk("R1 stat", 32'h24, 32'h0);
        reg_chk("R1 rfsh", 32'h30, 32'h05F0_0000);
        reg_chk("R1 pwr", 32'h34, 32'h07C0_0000);
        for (int i = 0; i < 4; i++) reg_chk("R1 bank", 32'h40 + 4 * i, 32'h0);
        reg_chk("R1 time", 32'h80, 32'h0085_4009);
        reg_chk("R1 ecfg", 32'h94, 32'h0);
        reg_chk("R1 ests", 32'h98, 32'h0);
        chk("R1 irq", {31'b0, ecc_irq}, 32'h0);
        chk("R1 hit", {28'b0, bank_hit}, 32'h0);
    endtask

    task automatic t_ports;
        logic [31:0] v;
        port_wr(P_OFS, 32'h0000_0020);
        port_rd(P_OFS, v);  chk("R2 offset readback", v, 32'h20);
        port_rd(10'h012, v); chk("R2 other index", v, 32'h0);
        port_rd(P_DAT, v);  chk("R2 data selects cfg", v, 32'h0080_0000);
    endtask

    task automatic t_unknown;
        reg_chk("R3 unknown 0x04", 32'h04, 32'hFFFF_FFFF);
        reg_chk("R3 unknown 0x50", 32'h50, 32'hFFFF_FFFF);
    endtask

    task automatic t_err;
        reg_wr(32'h00, 32'hFFFF_FFFF); reg_chk("R4 err0 w1c", 32'h00, 32'h0);
        reg_wr(32'h08, 32'hA5A5_A5A5); reg_chk("R4 err1 w1c", 32'h08, 32'h0);
        reg_wr(32'h10, 32'h1234_5678); reg_chk("R4 eadr", 32'h10, 32'h1234_5678);
    endtask

    task automatic t_cfg;
        reg_wr(32'h20, 32'hFFFF_FFFF);
        reg_chk("R5 cfg mask", 32'h20, 32'hFFE0_0000);
        reg_chk("R6 stat bit30 set", 32'h24, 32'h4000_0000);
        reg_wr(32'h20, 32'h0);
        reg_chk("R5 disable sets stat31", 32'h24, 32'h8000_0000);
        reg_wr(32'h20, 32'h8000_0000);
        reg_chk("R5 enable clears stat31", 32'h24, 32'h0);
        reg_wr(32'h24, 32'hFFFF_FFFF);
        reg_chk("R6 stat readonly", 32'h24, 32'h0);
    endtask

    task automatic t_masks;
        reg_wr(32'h30, 32'hFFFF_FFFF); reg_chk("R7 rfsh", 32'h30, 32'h3FF8_0000);
        reg_wr(32'h80, 32'hFFFF_FFFF); reg_chk("R7 time", 32'h80, 32'h018F_C01F);
        reg_wr(32'h94, 32'hFFFF_FFFF); reg_chk("R7 ecfg", 32'h94, 32'h00F0_0000);
        reg_wr(32'h34, 32'h0);         reg_chk("R7 pwr zero", 32'h34, 32'h07C0_0000);
        reg_wr(32'h34, 32'hFFFF_FFFF); reg_chk("R7 pwr ones", 32'h34, 32'hFFC0_0000);
    endtask

    task automatic t_bank_mask;
        reg_wr(32'h40, 32'hFFFF_FFFF); reg_chk("R8 bank0 mask", 32'h40, 32'hFFDE_E001);
        phys_addr = 32'hFF80_0000;
        #1 chk("R9 code7 never hits", {28'b0, bank_hit}, 32'h0);
    endtask

    task automatic t_decode;
        reg_wr(32'h40, 32'h1002_0001);
        phys_addr = 32'h1040_0000; #1 chk("R9 inside 8MB", {28'b0, bank_hit}, 32'h1);
        phys_addr = 32'h1080_0000; #1 chk("R9 above window", {28'b0, bank_hit}, 32'h0);
        phys_addr = 32'h107F_FFFC; #1 chk("R9 top of window", {28'b0, bank_hit}, 32'h1);
        reg_wr(32'h48, 32'h200E_0001);
        phys_addr = 32'h2000_0000; #1 chk("R9 bank2 code7", {28'b0, bank_hit}, 32'h0);
        reg_wr(32'h4C, 32'h3004_0000);
        phys_addr = 32'h3000_0000; #1 chk("R9 bank3 not valid", {28'b0, bank_hit}, 32'h0);
        reg_wr(32'h20, 32'h0);
        phys_addr = 32'h1040_0000; #1 chk("R5 disabled no hit", {28'b0, bank_hit}, 32'h0);
        reg_wr(32'h20, 32'h8000_0000);
        #1 chk("R5 re-enabled hit", {28'b0, bank_hit}, 32'h1);
    endtask

    task automatic t_overlap;
        reg_wr(32'h44, 32'h1006_0001);
        phys_addr = 32'h1000_0000; #1 chk("R10 lowest wins", {28'b0, bank_hit}, 32'h1);
        phys_addr = 32'h1100_0000; #1 chk("R10 bank1 alone", {28'b0, bank_hit}, 32'h2);
    endtask

    task automatic t_same_cycle;
        phys_addr = 32'h4000_0000;
        port_wr(P_OFS, 32'h4C);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_sel = P_DAT; acc_wdata = 32'h4000_0001;
        #3 chk("R9 hit before capture edge", {28'b0, bank_hit}, 32'h0);
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
        #1 chk("R9 hit after capture edge", {28'b0, bank_hit}, 32'h8);
        port_wr(P_OFS, 32'h20);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_sel = P_DAT; acc_wdata = 32'h0;
        #3 chk("R5 hit before disable edge", {28'b0, bank_hit}, 32'h8);
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
        #1 chk("R5 no hit after disable edge", {28'b0, bank_hit}, 32'h0);
    endtask

    task automatic t_ecc;
        chk("R11 irq idle", {31'b0, ecc_irq}, 32'h0);
        reg_wr(32'h98, 32'hFFFF_FFFF);
        reg_chk("R11 ests mask", 32'h98, 32'hFFF0_F000);
        chk("R11 irq raised", {31'b0, ecc_irq}, 32'h1);
        reg_wr(32'h98, 32'h000F_0FFF);
        reg_chk("R11 masked to zero", 32'h98, 32'h0);
        chk("R11 irq lowered", {31'b0, ecc_irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_ports;
        t_unknown;
        t_err;
        t_cfg;
        t_masks;
        t_bank_mask;
        t_decode;
        t_overlap;
        t_same_cycle;
        t_ecc;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule